// File: doc/BRIEF.md
# PCIe Root Port Link Bring-Up Sequencer

This block runs the timed start-up of a PCIe root port after power-on and decides whether the link can be used. When `start` is pulsed, it clears all three bits of its port control word: the reset-source select, the keep-alive-through-reset mode and the endpoint reset output. This holds the endpoint in reset for a fixed interval. The block then raises the reset output alone. It waits a longer settle interval and then judges the port from its status inputs: PHY link state, data-link-layer state, configuration header type and negotiated link width.

If the link width reads as zero and the programmed target speed is second generation (code 2), the block rewrites the target speed to first generation (code 1). It then waits one more settle interval and checks the width a second time. At most one such retry is made. The run ends with `done` high together with exactly one of `link_up` or `link_fail`, and a cause code explains any failure. Both intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter, so a simulation can use short intervals.

Top module: `rp_bringup_seq`

## Requirements
- R1: Out of reset, `ctl` equals the parameter `CTL_POR` (default 3'b110), `tgt_speed` is 0, and `done`, `link_up`, `link_fail` and `fail_cause` are all 0.
- R2: A `start` pulse accepted while idle or finished sets all of `ctl` to 3'b000 on the next edge. `ctl[0]` (endpoint reset output) stays low for exactly RST_CYC = CLK_HZ/1e6*RST_US cycles.
- R3: After the hold, `ctl` becomes 3'b001 (bit 2 source select and bit 1 keep-alive stay clear). A first-pass verdict raises `done` SETTLE_CYC+1 cycles after `ctl[0]` rises, where SETTLE_CYC = CLK_HZ/1e6*SETTLE_US.
- R4: If `phy_link_up` or `dl_active` is low at the first check, the run ends with `link_fail`=1 and `fail_cause`=1, and no retry is made.
- R5: With both status bits high, a header type whose low 7 bits (hdr_type & 8'h7f) differ from 7'h01 (bridge) ends the run with `link_fail`=1 and `fail_cause`=2. Bit 7 is ignored.
- R6: With status and header good, a nonzero `link_width` ends the run with `link_up`=1 and `fail_cause`=0.
- R7: With status and header good, a zero width while `tgt_speed` equals 2 rewrites `tgt_speed` to 1. The block waits a second SETTLE_CYC interval and re-reads the width only, so `done` rises 2*SETTLE_CYC+2 cycles after `ctl[0]` rises.
- R8: With status and header good, a zero width while `tgt_speed` is not 2 ends the run at once with `link_fail`=1 and `fail_cause`=3, and `tgt_speed` is left unchanged.
- R9: A zero width on the retry check ends the run with `link_fail`=1 and `fail_cause`=3. A nonzero width there gives `link_up`=1.
- R10: While `done` is high, exactly one of `link_up` and `link_fail` is high. The results hold until the next accepted `start`, which clears `done`, `link_up` and `link_fail` on the next edge.
- R11: A `start` pulse during a run in progress is ignored, and the run's timing and result are unchanged.
- R12: `tgt_speed` loads `speed_cfg` when `start` is accepted. It changes only by that load or by the single 2-to-1 rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (accepted when idle or finished) |
| phy_link_up | input | 1 | PHY reports link up |
| dl_active | input | 1 | Data link layer reports active |
| hdr_type | input | 8 | Root port configuration header type |
| link_width | input | 6 | Negotiated link width, zero means inactive |
| speed_cfg | input | 4 | Target link speed code loaded at start |
| ctl | output | 3 | Port control: bit 2 reset-source select, bit 1 keep-alive mode, bit 0 endpoint reset output |
| tgt_speed | output | 4 | Current target link speed code |
| done | output | 1 | Run finished, verdict valid |
| link_up | output | 1 | Link usable |
| link_fail | output | 1 | Link not usable |
| fail_cause | output | 2 | 0 none, 1 status down, 2 endpoint mode, 3 zero width |

## Verification
On every cycle, the assertions check the following. The verdict flags are mutually exclusive and appear only with `done`. The control word moves only from all-clear to reset-released. A release or finish never leaves the side bits set. The target speed changes only by a start load or the single 2-to-1 downgrade. The bench scenarios are the only evidence for the exact hold and settle lengths in cycles, for which verdict each input pattern produces, and for the header mask. They also show that a busy-time start is truly ignored and that a retry happens only for a Gen2 target, with the width re-read after the second wait.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_CHECK,
    ST_RETRY,
    ST_RECHECK,
    ST_FINISH
  } rpb_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_DOWN  = 2'd1,
    CAUSE_EP    = 2'd2,
    CAUSE_WIDTH = 2'd3
  } rpb_cause_e;

  typedef struct packed {
    logic       pass;
    logic       retry;
    rpb_cause_e cause;
  } rpb_verdict_t;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_SRCSEL = 2;
  localparam int unsigned CTL_KEEP   = 1;
  localparam int unsigned CTL_EPRST  = 0;

  localparam int unsigned SPD_W      = 4;
  localparam logic [SPD_W-1:0] SPD_GEN1 = 4'd1;
  localparam logic [SPD_W-1:0] SPD_GEN2 = 4'd2;

  localparam logic [7:0] HDR_TYPE_MASK = 8'h7f;
  localparam logic [7:0] HDR_BRIDGE    = 8'h01;

endpackage

// File: rtl/rpb_timer.sv
module rpb_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rpb_link_eval.sv
module rpb_link_eval
  import rpb_pkg::*;
#(
  parameter int unsigned WIDTH_W = 6
) (
  input  logic               second_pass,
  input  logic               phy_up,
  input  logic               dl_up,
  input  logic [7:0]         hdr,
  input  logic [WIDTH_W-1:0] width,
  input  logic [SPD_W-1:0]   speed,
  output rpb_verdict_t       verdict
);

  logic width_ok;
  logic is_bridge;

  assign width_ok  = (width != '0);
  assign is_bridge = ((hdr & HDR_TYPE_MASK) == HDR_BRIDGE);

  always_comb begin
    verdict.pass  = 1'b0;
    verdict.retry = 1'b0;
    verdict.cause = CAUSE_NONE;
    if (second_pass) begin
      if (width_ok) verdict.pass  = 1'b1;
      else          verdict.cause = CAUSE_WIDTH;
    end else if (!phy_up || !dl_up) begin
      verdict.cause = CAUSE_DOWN;
    end else if (!is_bridge) begin
      verdict.cause = CAUSE_EP;
    end else if (width_ok) begin
      verdict.pass = 1'b1;
    end else if (speed == SPD_GEN2) begin
      verdict.retry = 1'b1;
    end else begin
      verdict.cause = CAUSE_WIDTH;
    end
  end

endmodule

// File: rtl/rpb_port_regs.sv
module rpb_port_regs
  import rpb_pkg::*;
#(
  parameter logic [2:0] CTL_POR = 3'b110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clear,
  input  logic             ctl_release,
  input  logic             spd_load,
  input  logic             spd_down,
  input  logic [SPD_W-1:0] spd_cfg,
  output logic [CTL_W-1:0] ctl_q,
  output logic [SPD_W-1:0] spd_q
);

  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;
  logic [SPD_W-1:0] spd_d;
  logic             spd_en;

  assign ctl_en = ctl_clear || ctl_release;
  assign spd_en = spd_load || spd_down;

  always_comb begin
    ctl_d = '0;
    if (ctl_release) ctl_d[CTL_EPRST] = 1'b1;
    ctl_d[CTL_SRCSEL] = 1'b0;
    ctl_d[CTL_KEEP]   = 1'b0;
  end

  always_comb begin
    if (spd_load) spd_d = spd_cfg;
    else          spd_d = SPD_GEN1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_POR;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      spd_q <= '0;
    else if (spd_en) spd_q <= spd_d;
  end

endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
  import rpb_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned RST_US    = 250,
  parameter int unsigned SETTLE_US = 100_000,
  parameter int unsigned WIDTH_W   = 6,
  parameter logic [2:0]  CTL_POR   = 3'b110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               phy_link_up,
  input  logic               dl_active,
  input  logic [7:0]         hdr_type,
  input  logic [WIDTH_W-1:0] link_width,
  input  logic [3:0]         speed_cfg,
  output logic [2:0]         ctl,
  output logic [3:0]         tgt_speed,
  output logic               done,
  output logic               link_up,
  output logic               link_fail,
  output logic [1:0]         fail_cause
);

  localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned RST_CYC    = (CYC_PER_US * RST_US > 0) ? CYC_PER_US * RST_US : 1;
  localparam int unsigned SETTLE_CYC = (CYC_PER_US * SETTLE_US > 0) ? CYC_PER_US * SETTLE_US : 1;
  localparam int unsigned MAX_CYC    = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RST_LD    = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  rpb_state_e       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             ctl_clear, ctl_release;
  logic             spd_load, spd_down;
  logic             res_clear, res_set;
  rpb_verdict_t     verdict;

  logic             done_q, up_q, fail_q;
  rpb_cause_e       cause_q;

  rpb_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  rpb_port_regs #(.CTL_POR(CTL_POR)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_clear   (ctl_clear),
    .ctl_release (ctl_release),
    .spd_load    (spd_load),
    .spd_down    (spd_down),
    .spd_cfg     (speed_cfg),
    .ctl_q       (ctl),
    .spd_q       (tgt_speed)
  );

  rpb_link_eval #(.WIDTH_W(WIDTH_W)) u_eval (
    .second_pass (state_q == ST_RECHECK),
    .phy_up      (phy_link_up),
    .dl_up       (dl_active),
    .hdr         (hdr_type),
    .width       (link_width),
    .speed       (tgt_speed),
    .verdict     (verdict)
  );

  // next-state and command decode
  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = SETTLE_LD;
    ctl_clear   = 1'b0;
    ctl_release = 1'b0;
    spd_load    = 1'b0;
    spd_down    = 1'b0;
    res_clear   = 1'b0;
    res_set     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_FINISH: begin
        if (start) begin
          state_d   = ST_HOLD;
          tmr_load  = 1'b1;
          tmr_val   = RST_LD;
          ctl_clear = 1'b1;
          spd_load  = 1'b1;
          res_clear = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          state_d     = ST_SETTLE;
          tmr_load    = 1'b1;
          ctl_release = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (verdict.retry) begin
          state_d  = ST_RETRY;
          tmr_load = 1'b1;
          spd_down = 1'b1;
        end else begin
          state_d = ST_FINISH;
          res_set = 1'b1;
        end
      end
      ST_RETRY: begin
        if (tmr_expired) state_d = ST_RECHECK;
      end
      ST_RECHECK: begin
        state_d = ST_FINISH;
        res_set = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      up_q    <= 1'b0;
      fail_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (res_set) begin
      done_q  <= 1'b1;
      up_q    <= verdict.pass;
      fail_q  <= !verdict.pass;
      cause_q <= verdict.cause;
    end else if (res_clear) begin
      done_q  <= 1'b0;
      up_q    <= 1'b0;
      fail_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end
  end

  assign done       = done_q;
  assign link_up    = up_q;
  assign link_fail  = fail_q;
  assign fail_cause = cause_q;

endmodule

// File: rtl/rpb_checker.sv
module rpb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] ctl,
  input logic [3:0] tgt_speed,
  input logic       done,
  input logic       link_up,
  input logic       link_fail,
  input logic [1:0] fail_cause
);

  // R10: exactly one verdict flag while done
  a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (link_up ^ link_fail));

  // R10: no verdict flag without done
  a_r10_no_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!link_up && !link_fail));

  // R6, R4: passing runs carry no cause, failing runs carry one
  a_r6_cause_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (fail_cause == 2'd0));

  a_r4_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> (fail_cause != 2'd0));

  // R3: leaving the all-clear word only goes to reset released
  a_r3_release_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 3'b000) |=> (ctl == 3'b000 || ctl == 3'b001));

  // R3: done never rises while the endpoint is held in reset
  a_r3_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (ctl == 3'b001));

  // R12: target speed moves only by a start load or the 2-to-1 rewrite
  a_r12_speed_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgt_speed) |-> ($past(start) || ($past(tgt_speed) == 4'd2 && tgt_speed == 4'd1)));

endmodule

bind rp_bringup_seq rpb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ctl        (ctl),
  .tgt_speed  (tgt_speed),
  .done       (done),
  .link_up    (link_up),
  .link_fail  (link_fail),
  .fail_cause (fail_cause)
);

// File: tb/rp_bringup_seq_tb.sv
module rp_bringup_seq_tb;

  localparam int unsigned CLK_HZ    = 1_000_000;
  localparam int unsigned RST_US    = 12;
  localparam int unsigned SETTLE_US = 30;
  localparam int         RST_CYC    = 12;
  localparam int         SET_CYC    = 30;
  localparam int         LIMIT      = 5000;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       phy_link_up;
  logic       dl_active;
  logic [7:0] hdr_type;
  logic [5:0] link_width;
  logic [3:0] speed_cfg;
  logic [2:0] ctl;
  logic [3:0] tgt_speed;
  logic       done;
  logic       link_up;
  logic       link_fail;
  logic [1:0] fail_cause;

  int n_checks;
  int n_fails;
  int lo_cnt;
  int hi_cnt;
  logic [2:0] ctl_first;

  rp_bringup_seq #(
    .CLK_HZ(CLK_HZ), .RST_US(RST_US), .SETTLE_US(SETTLE_US),
    .WIDTH_W(6), .CTL_POR(3'b110)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phy_link_up(phy_link_up), .dl_active(dl_active),
    .hdr_type(hdr_type), .link_width(link_width), .speed_cfg(speed_cfg),
    .ctl(ctl), .tgt_speed(tgt_speed), .done(done),
    .link_up(link_up), .link_fail(link_fail), .fail_cause(fail_cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // mode 0 plain, 1 raise width once speed is rewritten, 2 busy start pulse
  task automatic launch(input logic phy, input logic dl, input logic [7:0] hdr,
                        input logic [5:0] wid, input logic [3:0] spd, input int mode);
    phy_link_up = phy; dl_active = dl; hdr_type = hdr;
    link_width = wid; speed_cfg = spd;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ctl_first = ctl;
    lo_cnt = 0;
    while (ctl[0] == 1'b0 && lo_cnt < LIMIT) begin
      lo_cnt++;
      @(negedge clk);
    end
    hi_cnt = 0;
    while (!done && hi_cnt < LIMIT) begin
      start = (mode == 2 && hi_cnt == 5);
      if (mode == 1 && tgt_speed == 4'd1) link_width = 6'd2;
      hi_cnt++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctl", ctl, 3'b110);
    check("R1 speed", tgt_speed, 0);
    check("R1 done", done, 0);
    check("R1 up/fail", {link_up, link_fail}, 0);
    check("R1 cause", fail_cause, 0);
  endtask

  task automatic t_good();
    launch(1, 1, 8'h81, 6'd4, 4'd2, 0);
    check("R2 ctl cleared", ctl_first, 3'b000);
    check("R2 hold length", lo_cnt, RST_CYC);
    check("R3 settle length", hi_cnt, SET_CYC + 1);
    check("R3 ctl released", ctl, 3'b001);
    check("R6 link_up", link_up, 1);
    check("R6 cause", fail_cause, 0);
    check("R10 fail low", link_fail, 0);
    check("R12 speed loaded", tgt_speed, 2);
  endtask

  task automatic t_restart_clears();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10 done cleared", done, 0);
    check("R10 up cleared", link_up, 0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_phy_down();
    launch(0, 1, 8'h01, 6'd4, 4'd2, 0);
    check("R4 fail phy", {link_fail, link_up}, 2'b10);
    check("R4 cause phy", fail_cause, 1);
    check("R4 no retry", hi_cnt, SET_CYC + 1);
    check("R4 speed kept", tgt_speed, 2);
  endtask

  task automatic t_dl_down();
    launch(1, 0, 8'h01, 6'd4, 4'd2, 0);
    check("R4 fail dl", link_fail, 1);
    check("R4 cause dl", fail_cause, 1);
  endtask

  task automatic t_endpoint();
    launch(1, 1, 8'h80, 6'd4, 4'd2, 0);
    check("R5 fail ep", link_fail, 1);
    check("R5 cause ep", fail_cause, 2);
  endtask

  task automatic t_retry_ok();
    launch(1, 1, 8'h01, 6'd0, 4'd2, 1);
    check("R7 speed rewritten", tgt_speed, 1);
    check("R7 retry timing", hi_cnt, 2 * SET_CYC + 2);
    check("R9 retry link_up", link_up, 1);
  endtask

  task automatic t_retry_fail();
    launch(1, 1, 8'h01, 6'd0, 4'd2, 0);
    check("R9 retry fail", link_fail, 1);
    check("R9 cause width", fail_cause, 3);
    check("R7 timing", hi_cnt, 2 * SET_CYC + 2);
  endtask

  task automatic t_no_retry();
    launch(1, 1, 8'h01, 6'd0, 4'd3, 0);
    check("R8 fail", link_fail, 1);
    check("R8 cause", fail_cause, 3);
    check("R8 speed kept", tgt_speed, 3);
    check("R8 timing", hi_cnt, SET_CYC + 1);
  endtask

  task automatic t_busy_start();
    launch(1, 1, 8'h01, 6'd8, 4'd1, 2);
    check("R11 hold", lo_cnt, RST_CYC);
    check("R11 timing", hi_cnt, SET_CYC + 1);
    check("R11 result", link_up, 1);
    check("R11 ctl", ctl, 3'b001);
  endtask

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; start = 1'b0;
    phy_link_up = 1'b0; dl_active = 1'b0; hdr_type = '0;
    link_width = '0; speed_cfg = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_restart_clears();
    t_phy_down();
    t_dl_down();
    t_endpoint();
    t_retry_ok();
    t_retry_fail();
    t_no_retry();
    t_busy_start();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule